// File: doc/BRIEF.md
# Dual-Mode Serial 1-0-1 Pattern Detector

This block watches a serial bit stream, one qualified bit per clock, and raises a single-cycle flag whenever the bits 1, 0, 1 arrive in that order. A mode input chooses between two matching rules.

In sliding mode, the search never pauses. The closing 1 of one match also serves as the opening 1 of the next, so the stream 1,0,1,0,1 produces two hits. In framed mode, the stream is cut into aligned groups of three qualified bits, counted from the first qualified bit after reset. A hit is reported only when a whole group reads 1,0,1. No bit belongs to more than one group, so a 1-0-1 that crosses a group boundary is never reported.

The flag is combinational from the registered history and the current bit. It therefore rises in the same cycle in which the closing bit is presented. Bits presented with the valid input low are invisible to the block.

Top module: `pat101_detector`

## Requirements
- R1: `hit_o` is high only in a cycle where `bit_valid_i`=1 and `bit_i`=1 complete a 1-0-1 under the active mode rule, and low in every other cycle; it is produced in that same cycle, with no register delay.
- R2: In sliding mode (`frame_mode_i`=0), the closing 1 of a match can open the next match; the input 0,1,0,1,0,1,0,1 gives 0,0,0,1,0,1,0,1.
- R3: In sliding mode, a 0 received right after the bits 1,0 discards the partial match; the input 1,0,0,1,0,1 hits only on the sixth bit.
- R4: In framed mode (`frame_mode_i`=1), qualified bits form aligned groups of three, counted from the first qualified bit after reset; a hit is given on the third bit of a group whose bits, in arrival order, are 1,0,1.
- R5: In framed mode, each bit belongs to exactly one group; a 1-0-1 spanning two groups is never reported (0,1,0,1,0,0 gives no hit).
- R6: While `bit_valid_i`=0, `hit_o` is 0 and neither the sliding-mode history nor the framed-mode position counter changes.
- R7: `frame_mode_i` is captured at the first clock edge after reset release; changes after that have no effect until the next reset.
- R8: `rst_n` low clears the match history and the group counter asynchronously and forces `hit_o` low; after release, framing restarts at the first bit of a group.
- R9: `hit_o` is never high on two consecutive qualified bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_mode_i | input | 1 | 1 selects framed matching, 0 selects sliding matching; captured after reset |
| bit_valid_i | input | 1 | Qualifies `bit_i` in this cycle |
| bit_i | input | 1 | Serial data bit |
| hit_o | output | 1 | High in the cycle the closing bit of a reported 1-0-1 is presented |

## Verification
Every hit is due in the very cycle its closing bit is driven, because the flag is formed combinationally from state registered on earlier edges. The bench therefore drives each bit just after a falling edge and samples `hit_o` one time unit later, before the rising edge that commits the bit. The bench also checks two effects that show up only on a later bit: the counter is held during valid gaps, and the mode is captured once after reset. For these, it drives further qualified bits and compares the flag each one produces. The asynchronous clear is sampled inside the clock phase in which reset falls.

// File: rtl/pat101_pkg.sv
package pat101_pkg;

  // group length for framed mode and the pattern being searched for
  localparam int unsigned GROUP_LEN = 3;
  localparam logic [GROUP_LEN-1:0] MATCH_PAT = 3'b101;

  // sliding-mode history states
  typedef enum logic [1:0] {
    SL_IDLE   = 2'd0,
    SL_GOT1   = 2'd1,
    SL_GOT10  = 2'd2
  } slide_state_e;

endpackage

// File: rtl/pat101_mode_latch.sv
module pat101_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  output logic mode_o,
  output logic armed_o
);

  logic mode_q, mode_d;
  logic armed_q, armed_d;

  // capture once, on the first edge after reset release
  always_comb begin
    mode_d  = mode_q;
    armed_d = armed_q;
    if (!armed_q) begin
      mode_d  = mode_i;
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      armed_q <= armed_d;
    end
  end

  // before capture the live pin decides, afterwards the held copy
  assign mode_o  = armed_q ? mode_q : mode_i;
  assign armed_o = armed_q;

endmodule

// File: rtl/pat101_slide_fsm.sv
module pat101_slide_fsm
  import pat101_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic bit_i,
  output logic match_o
);

  slide_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (en_i) begin
      unique case (state_q)
        SL_IDLE:  state_d = bit_i ? SL_GOT1 : SL_IDLE;
        SL_GOT1:  state_d = bit_i ? SL_GOT1 : SL_GOT10;
        SL_GOT10: state_d = bit_i ? SL_GOT1 : SL_IDLE;
        default:  state_d = SL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SL_IDLE;
    else        state_q <= state_d;
  end

  assign match_o = en_i && bit_i && (state_q == SL_GOT10);

endmodule

// File: rtl/pat101_group_chk.sv
module pat101_group_chk
  import pat101_pkg::*;
#(
  parameter int unsigned LEN = GROUP_LEN,
  parameter logic [LEN-1:0] PAT = MATCH_PAT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic bit_i,
  output logic match_o
);

  localparam int unsigned CW = $clog2(LEN);
  localparam logic [CW-1:0] LAST_POS = CW'(LEN - 1);

  logic [CW-1:0]  pos_q, pos_d;
  logic [LEN-2:0] hist_q, hist_d;
  logic [LEN-1:0] group;

  assign group = {hist_q, bit_i};

  always_comb begin
    pos_d  = pos_q;
    hist_d = hist_q;
    if (en_i) begin
      pos_d = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
      if (LEN > 2) hist_d = {hist_q[LEN-3:0], bit_i};
      else         hist_d = bit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      hist_q <= '0;
    end else begin
      pos_q  <= pos_d;
      hist_q <= hist_d;
    end
  end

  assign match_o = en_i && (pos_q == LAST_POS) && (group == PAT);

endmodule

// File: rtl/pat101_detector.sv
module pat101_detector (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_mode_i,
  input  logic bit_valid_i,
  input  logic bit_i,
  output logic hit_o
);

  logic mode_frame;
  logic mode_armed;
  logic slide_hit;
  logic group_hit;

  pat101_mode_latch u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (frame_mode_i),
    .mode_o  (mode_frame),
    .armed_o (mode_armed)
  );

  pat101_slide_fsm u_slide (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (bit_valid_i),
    .bit_i   (bit_i),
    .match_o (slide_hit)
  );

  pat101_group_chk u_group (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (bit_valid_i),
    .bit_i   (bit_i),
    .match_o (group_hit)
  );

  assign hit_o = mode_frame ? group_hit : slide_hit;

endmodule

// File: rtl/pat101_detector_chk.sv
module pat101_detector_chk
  import pat101_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid_i,
  input  logic bit_i,
  input  logic hit_o,
  input  logic mode_frame,
  input  logic mode_armed
);

  // independent count of qualified beats within a group
  localparam int unsigned BW = $clog2(GROUP_LEN);
  logic [BW-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else if (bit_valid_i) beat_q <= (beat_q == BW'(GROUP_LEN - 1)) ? '0 : beat_q + 1'b1;
  end

  assert_quiet_when_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> bit_valid_i);

  assert_hit_on_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> bit_i);

  assert_group_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_frame && hit_o) |-> (beat_q == BW'(GROUP_LEN - 1)));

  assert_no_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !hit_o);

  assert_mode_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_armed && $past(mode_armed)) |-> $stable(mode_frame));

endmodule

bind pat101_detector pat101_detector_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_valid_i (bit_valid_i),
  .bit_i       (bit_i),
  .hit_o       (hit_o),
  .mode_frame  (mode_frame),
  .mode_armed  (mode_armed)
);

// File: tb/pat101_detector_tb.sv
module pat101_detector_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        mode;
    logic [4:0]  len;
    logic [31:0] din;   // first bit is din[len-1]
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 5'd8,  32'b01010101,             32'b00010101},
    '{1'b0, 5'd17, 32'b10010001001010100,    32'b00000000000010100},
    '{1'b1, 5'd19, 32'b1001100101010101010,  32'b0000000000010000010},
    '{1'b0, 5'd7,  32'b1011011,              32'b0010010},
    '{1'b1, 5'd9,  32'b101101010,            32'b001001000},
    '{1'b0, 5'd6,  32'b100101,               32'b000001},
    '{1'b1, 5'd6,  32'b010100,               32'b000000}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic frame_mode_i;
  logic bit_valid_i;
  logic bit_i;
  logic hit_o;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pat101_detector dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_mode_i (frame_mode_i),
    .bit_valid_i  (bit_valid_i),
    .bit_i        (bit_i),
    .hit_o        (hit_o)
  );

  function automatic string vec_req(int i);
    case (i)
      0: return "R2/R9";
      1: return "R1/R2";
      2: return "R4/R5";
      3: return "R2";
      4: return "R4";
      5: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: hit_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(logic m);
    @(negedge clk);
    rst_n = 1'b0;
    frame_mode_i = m;
    bit_valid_i = 1'b0;
    bit_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive one beat after the falling edge, sample before the rising edge
  task automatic beat(logic v, logic b, logic exp, string req);
    @(negedge clk);
    bit_valid_i = v;
    bit_i = b;
    #1;
    check(req, hit_o, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    frame_mode_i = 1'b0;
    bit_valid_i = 1'b0;
    bit_i = 1'b0;

    // reset state R8 and idle response R1
    do_reset(1'b0);
    #1 check("R8", hit_o, 1'b0);
    beat(1'b1, 1'b1, 1'b0, "R1");

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      do_reset(VECS[i].mode);
      for (int k = 0; k < int'(VECS[i].len); k++) begin
        beat(1'b1, VECS[i].din[VECS[i].len - 1 - k],
             VECS[i].exp[VECS[i].len - 1 - k], vec_req(i));
      end
    end

    // R6: sliding history held across a valid gap
    do_reset(1'b0);
    beat(1'b1, 1'b1, 1'b0, "R6");
    beat(1'b1, 1'b0, 1'b0, "R6");
    for (int g = 0; g < 3; g++) beat(1'b0, 1'b1, 1'b0, "R6");
    beat(1'b1, 1'b1, 1'b1, "R6");

    // R6: group counter held across a valid gap
    do_reset(1'b1);
    beat(1'b1, 1'b1, 1'b0, "R6");
    beat(1'b1, 1'b0, 1'b0, "R6");
    for (int g = 0; g < 4; g++) beat(1'b0, g[0], 1'b0, "R6");
    beat(1'b1, 1'b1, 1'b1, "R6");

    // R7: mode change after capture ignored (sliding kept)
    do_reset(1'b0);
    beat(1'b1, 1'b0, 1'b0, "R7");
    frame_mode_i = 1'b1;
    beat(1'b1, 1'b1, 1'b0, "R7");
    beat(1'b1, 1'b0, 1'b0, "R7");
    beat(1'b1, 1'b1, 1'b1, "R7");

    // R7: mode change after capture ignored (framed kept)
    do_reset(1'b1);
    beat(1'b1, 1'b0, 1'b0, "R7");
    frame_mode_i = 1'b0;
    beat(1'b1, 1'b1, 1'b0, "R7");
    beat(1'b1, 1'b0, 1'b0, "R7");
    beat(1'b1, 1'b1, 1'b0, "R7");

    // R8: reset mid-group restarts framing
    do_reset(1'b1);
    beat(1'b1, 1'b0, 1'b0, "R8");
    beat(1'b1, 1'b1, 1'b0, "R8");
    do_reset(1'b1);
    beat(1'b1, 1'b1, 1'b0, "R8");
    beat(1'b1, 1'b0, 1'b0, "R8");
    beat(1'b1, 1'b1, 1'b1, "R8");

    // R8: asynchronous clear drops a pending hit within the cycle
    do_reset(1'b0);
    beat(1'b1, 1'b1, 1'b0, "R8");
    beat(1'b1, 1'b0, 1'b0, "R8");
    beat(1'b1, 1'b1, 1'b1, "R8");
    #1 rst_n = 1'b0;
    #1 check("R8", hit_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    bit_valid_i = 1'b0;

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule